// File: doc/BRIEF.md
# Serial Configuration Port with CRC-8 Protection

This block is the slave side of a four-wire serial configuration port: chip select, serial clock, serial data in and serial data out. All four lines are sampled in the system clock domain through synchronizer chains, and the serial clock edges are detected there. While chip select is high, the master shifts in a command frame, most significant bit first. The frame starts with a 4-bit command code. An address and a data field follow when the command carries them, and an 8-bit CRC closes the frame.

When the last CRC bit arrives, the port checks the frame. It then drives a single acknowledge bit on the data-out line: 1 when the frame is accepted and 0 when it is rejected. A rejected frame changes nothing. An accepted write is committed to a small register store a fixed number of serial clocks after the acknowledge, and only if chip select is still high. An accepted read shifts out the selected 16-bit register and then a CRC-8 computed over that data. The store holds one word per channel and one global word.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset the data-out line is 0. Every channel word and the global word read back as 0x0000. While chip select is low, data-out is 0.
- R2: The frame check is a CRC-8 with polynomial x^8+x^2+x+1 (0x07) and seed 0x8A. It runs MSB first over every frame bit that comes before the CRC field. The CRC field is sent MSB first. A frame that matches is acknowledged with data-out = 1, driven from the first serial falling edge after the last frame bit until the next falling edge.
- R3: A frame whose CRC does not match is answered with data-out = 0 in the acknowledge slot. It writes nothing and returns no read data (data-out stays 0).
- R4: There are four command codes. 0x1 writes a channel: code, 7-bit address, 16-bit data, CRC (35 bits). 0x2 reads a channel: code, address, CRC (19 bits). 0x3 writes the global word: code, 16-bit data, CRC (28 bits). 0x4 reads the global word: code, CRC (12 bits).
- R5: A channel command whose address is not below CHANNELS is rejected (acknowledge 0, no effect). Address CHANNELS-1 is accepted.
- R6: After an accepted read, each following serial falling edge drives the next bit on data-out: first the 16 data bits MSB first, then the CRC-8 (0x07, seed 0x8A) of those 16 bits, MSB first.
- R7: An accepted write is committed on the third serial rising edge after the acknowledge is driven. If chip select falls before that edge, the write is dropped.
- R8: Any other command code is treated as a 12-bit frame (code plus CRC) and is rejected with acknowledge 0.
- R9: Dropping chip select in the middle of a frame discards the partial frame. The next frame is decoded from its first bit.
- R10: Data-out changes only after a serial falling edge or when chip select goes low. It is 0 while a frame is being shifted in, after a write's acknowledge slot, and after the last read CRC bit.
- R11: The global word is stored apart from the channel words. Writing one leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select, active high, asynchronous to clk |
| sclk_i | input | 1 | Serial clock, well below the clk rate |
| sdi_i | input | 1 | Serial data in, sampled on serial rising edges |
| sdo_o | output | 1 | Serial data out, always driven, updated after serial falling edges |

## Verification
The bench builds the port with CHANNELS = 6 and two synchronizer stages. With six channels, address 5 is the last legal one and address 6 the first illegal one, so the range boundary can be reached with a 7-bit address. Each serial half-period spans eight system clocks. This leaves several settled cycles in every phase in which the reference model's expected data-out value is compared with the port's output. The port shares a single frame decoder across all codes. Because of that, the short global read, the longest channel write, unknown codes, corrupted CRCs and early chip-select release all go through the same decode path.

// File: rtl/spi_cfg_pkg.sv
// Package: shared constants, command codes, state encoding and CRC-8 helpers
// for the serial configuration port. Assumes MSB-first serial order.
package spi_cfg_pkg;

    localparam int CODE_W = 4;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 16;
    localparam int CRC_W  = 8;
    localparam int LEN_W  = 6;

    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
    localparam logic [CRC_W-1:0] CRC_SEED = 8'h8A;

    typedef enum logic [CODE_W-1:0] {
        CMD_WR_CH = 4'h1,
        CMD_RD_CH = 4'h2,
        CMD_WR_GL = 4'h3,
        CMD_RD_GL = 4'h4
    } cmd_e;

    typedef enum logic [2:0] {
        ST_SHIFT,
        ST_ACK,
        ST_WRWAIT,
        ST_RDOUT,
        ST_DONE
    } eng_state_e;

    // One serial step of the CRC-8 register.
    function automatic logic [CRC_W-1:0] crc8_bit(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    // CRC-8 of a whole data word, MSB first, from the seed.
    function automatic logic [CRC_W-1:0] crc8_word(input logic [DATA_W-1:0] d);
        logic [CRC_W-1:0] c;
        c = CRC_SEED;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            c = crc8_bit(c, d[i]);
        end
        return c;
    endfunction

    // Total frame length in bits for a command code; unknown codes use the short form.
    function automatic logic [LEN_W-1:0] frame_len(input logic [CODE_W-1:0] code);
        case (code)
            CMD_WR_CH: return LEN_W'(CODE_W + ADDR_W + DATA_W + CRC_W);
            CMD_RD_CH: return LEN_W'(CODE_W + ADDR_W + CRC_W);
            CMD_WR_GL: return LEN_W'(CODE_W + DATA_W + CRC_W);
            default:   return LEN_W'(CODE_W + CRC_W);
        endcase
    endfunction

endpackage

// File: rtl/cfg_sync_edge.sv
// Module: brings chip select, serial clock and serial data into the clk domain
// through STAGES flops each, and produces one-cycle pulses on serial clock edges.
// Assumes STAGES >= 2 and a serial clock at least four times slower than clk.
module cfg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_in,
    input  logic sclk_in,
    input  logic sdi_in,
    output logic cs_s,
    output logic sdi_s,
    output logic sclk_rise,
    output logic sclk_fall
);

    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] sclk_p;
    logic [STAGES-1:0] sdi_p;
    logic              sclk_prev;

    // Synchronizer chains for the three serial inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_p   <= '0;
            sclk_p <= '0;
            sdi_p  <= '0;
        end else begin
            cs_p   <= {cs_p[STAGES-2:0], cs_in};
            sclk_p <= {sclk_p[STAGES-2:0], sclk_in};
            sdi_p  <= {sdi_p[STAGES-2:0], sdi_in};
        end
    end

    // Delayed copy of the synchronized serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_p[STAGES-1];
    end

    assign cs_s      = cs_p[STAGES-1];
    assign sdi_s     = sdi_p[STAGES-1];
    assign sclk_rise = sclk_p[STAGES-1] & ~sclk_prev;
    assign sclk_fall = ~sclk_p[STAGES-1] & sclk_prev;

endmodule

// File: rtl/cfg_crc8_serial.sv
// Module: running CRC-8 over the incoming frame bits. It is cleared to the seed
// while clear is high and advances one bit per step pulse. crc_next shows the
// value after the current bit, so the frame check can use it in the same cycle.
module cfg_crc8_serial
    import spi_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_next
);

    logic [CRC_W-1:0] crc_q;

    assign crc_next = crc8_bit(crc_q, bit_in);

    // Remainder register: seed on clear, update on each received bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc_q <= CRC_SEED;
        else if (step)       crc_q <= crc_next;
    end

endmodule

// File: rtl/cfg_reg_bank.sv
// Module: configuration storage with one word per channel and one global word.
// Writes are single-cycle strobes from the frame engine. Reads are combinational.
// Assumes the engine only issues channel strobes for in-range addresses.
module cfg_reg_bank
    import spi_cfg_pkg::*;
#(
    parameter int CHANNELS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              wr_global,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] ch_rdata,
    output logic [DATA_W-1:0] gl_rdata
);

    logic [DATA_W-1:0] ch_mem [CHANNELS];
    logic [DATA_W-1:0] gl_q;

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        // Per-channel word, loaded when the strobe addresses this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) ch_mem[c] <= '0;
            else if (wr_stb && !wr_global && wr_addr == ADDR_W'(c)) ch_mem[c] <= wr_data;
        end
    end

    // Global word, loaded by global write strobes only.
    always_ff @(posedge clk) begin
        if (!rst_n)                 gl_q <= '0;
        else if (wr_stb && wr_global) gl_q <= wr_data;
    end

    // Channel read mux over the stored words.
    always_comb begin
        ch_rdata = '0;
        for (int c = 0; c < CHANNELS; c++) begin
            if (rd_addr == ADDR_W'(c)) ch_rdata = ch_mem[c];
        end
    end

    assign gl_rdata = gl_q;

    // R5
    wr_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_global) |-> (32'(wr_addr) < CHANNELS));

endmodule

// File: rtl/cfg_frame_engine.sv
// Module: decodes command frames from the synchronized serial stream, checks
// CRC, code and address, drives the acknowledge, commits writes and shifts out
// read data with its CRC. Assumes one-cycle edge pulses from cfg_sync_edge.
// All of its state returns to idle whenever chip select is low.
module cfg_frame_engine
    import spi_cfg_pkg::*;
#(
    parameter int CHANNELS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sdi_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    output logic              wr_stb,
    output logic              wr_global,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] ch_rdata,
    input  logic [DATA_W-1:0] gl_rdata,
    output logic              sdo
);

    localparam int PAY_W = ADDR_W + DATA_W;
    localparam int OUT_W = DATA_W + CRC_W;
    localparam int OCNT_W = $clog2(OUT_W + 1);

    eng_state_e          state;
    logic [LEN_W-1:0]    bitcnt;
    logic [PAY_W-2:0]    sh;
    logic [PAY_W-1:0]    s_next;
    logic [CODE_W-1:0]   code_q;
    logic [CODE_W-1:0]   code_cur;
    logic [LEN_W-1:0]    len_cur;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    logic                ok_q;
    logic                is_read_q;
    logic                is_glob_q;
    logic [OUT_W-1:0]    out_q;
    logic [OCNT_W-1:0]   outcnt;
    logic [1:0]          risecnt;
    logic                sdo_q;
    logic                wr_stb_q;
    logic [CRC_W-1:0]    crc_next;
    logic                in_shift_rise;
    logic                payload_end;
    logic                last_bit;
    logic                needs_addr;
    logic                code_known;
    logic                frame_ok;
    logic [DATA_W-1:0]   rd_data;

    cfg_crc8_serial i_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!cs_s),
        .step     (in_shift_rise),
        .bit_in   (sdi_s),
        .crc_next (crc_next)
    );

    // Frame decode: field positions, frame end and accept decision.
    always_comb begin
        s_next        = {sh, sdi_s};
        code_cur      = (bitcnt == LEN_W'(CODE_W - 1)) ? s_next[CODE_W-1:0] : code_q;
        len_cur       = frame_len(code_cur);
        in_shift_rise = sclk_rise && state == ST_SHIFT;
        payload_end   = in_shift_rise && bitcnt >= LEN_W'(CODE_W - 1)
                        && (bitcnt + LEN_W'(1) == len_cur - LEN_W'(CRC_W));
        last_bit      = in_shift_rise && bitcnt >= LEN_W'(CODE_W)
                        && (bitcnt + LEN_W'(1) == len_cur);
        needs_addr    = code_q == CMD_WR_CH || code_q == CMD_RD_CH;
        code_known    = code_q == CMD_WR_CH || code_q == CMD_RD_CH
                        || code_q == CMD_WR_GL || code_q == CMD_RD_GL;
        frame_ok      = crc_next == '0 && code_known
                        && (!needs_addr || 32'(addr_q) < CHANNELS);
        rd_data       = is_glob_q ? gl_rdata : ch_rdata;
    end

    // Serial state machine: shift, acknowledge, write wait, read out, done.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_s) begin
            state     <= ST_SHIFT;
            bitcnt    <= '0;
            sh        <= '0;
            code_q    <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            ok_q      <= 1'b0;
            is_read_q <= 1'b0;
            is_glob_q <= 1'b0;
            out_q     <= '0;
            outcnt    <= '0;
            risecnt   <= '0;
            sdo_q     <= 1'b0;
            wr_stb_q  <= 1'b0;
        end else begin
            wr_stb_q <= 1'b0;
            case (state)
                ST_SHIFT: begin
                    if (in_shift_rise) begin
                        sh     <= s_next[PAY_W-2:0];
                        bitcnt <= bitcnt + LEN_W'(1);
                        if (bitcnt == LEN_W'(CODE_W - 1)) code_q <= s_next[CODE_W-1:0];
                        if (payload_end) begin
                            addr_q <= (code_cur == CMD_WR_CH) ? s_next[PAY_W-1:DATA_W]
                                                              : s_next[ADDR_W-1:0];
                            data_q <= s_next[DATA_W-1:0];
                        end
                        if (last_bit) begin
                            ok_q      <= frame_ok;
                            is_read_q <= code_q == CMD_RD_CH || code_q == CMD_RD_GL;
                            is_glob_q <= code_q == CMD_WR_GL || code_q == CMD_RD_GL;
                            state     <= ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (sclk_fall) begin
                        sdo_q <= ok_q;
                        if (!ok_q) begin
                            state <= ST_DONE;
                        end else if (is_read_q) begin
                            out_q  <= {rd_data, crc8_word(rd_data)};
                            outcnt <= '0;
                            state  <= ST_RDOUT;
                        end else begin
                            risecnt <= '0;
                            state   <= ST_WRWAIT;
                        end
                    end
                end
                ST_WRWAIT: begin
                    if (sclk_fall) sdo_q <= 1'b0;
                    if (sclk_rise) begin
                        if (risecnt == 2'd2) begin
                            wr_stb_q <= 1'b1;
                            state    <= ST_DONE;
                        end else begin
                            risecnt <= risecnt + 2'd1;
                        end
                    end
                end
                ST_RDOUT: begin
                    if (sclk_fall) begin
                        if (outcnt < OCNT_W'(OUT_W)) begin
                            sdo_q  <= out_q[OUT_W-1];
                            out_q  <= {out_q[OUT_W-2:0], 1'b0};
                            outcnt <= outcnt + OCNT_W'(1);
                        end else begin
                            sdo_q <= 1'b0;
                            state <= ST_DONE;
                        end
                    end
                end
                default: begin
                    if (sclk_fall) sdo_q <= 1'b0;
                end
            endcase
        end
    end

    assign sdo       = sdo_q;
    assign wr_stb    = wr_stb_q;
    assign wr_global = is_glob_q;
    assign wr_addr   = addr_q;
    assign wr_data   = data_q;
    assign rd_addr   = addr_q;

    // R10
    sdo_quiet_in_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> !sdo_q);

    // R10
    sdo_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_q) |-> ($past(sclk_fall) || !$past(cs_s)));

    // R3
    commit_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_q |-> (ok_q && !is_read_q));

    // R7
    commit_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_q |-> $past(sclk_rise));

endmodule

// File: rtl/cfg_serial_port.sv
// Module (top): serial configuration port. Synchronizes the serial lines,
// decodes CRC-protected command frames and holds the configuration words.
// Assumes the serial clock runs at most a quarter of the clk rate.
module cfg_serial_port #(
    parameter int CHANNELS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sdo_o
);
    import spi_cfg_pkg::*;

    logic              cs_s;
    logic              sdi_s;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              wr_stb;
    logic              wr_global;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] ch_rdata;
    logic [DATA_W-1:0] gl_rdata;

    cfg_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_in     (cs_i),
        .sclk_in   (sclk_i),
        .sdi_in    (sdi_i),
        .cs_s      (cs_s),
        .sdi_s     (sdi_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    cfg_frame_engine #(.CHANNELS(CHANNELS)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .sdi_s     (sdi_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .wr_stb    (wr_stb),
        .wr_global (wr_global),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .ch_rdata  (ch_rdata),
        .gl_rdata  (gl_rdata),
        .sdo       (sdo_o)
    );

    cfg_reg_bank #(.CHANNELS(CHANNELS)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_global (wr_global),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .ch_rdata  (ch_rdata),
        .gl_rdata  (gl_rdata)
    );

endmodule

// File: tb/test_cfg_serial_port.sv
// Bench: a behavioural model of the serial protocol that compares data-out
// on every settled system clock.
module test_cfg_serial_port;

    localparam int CH = 6;
    localparam int HP = 8;
    localparam int SETTLE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo;

    int    cyc = 0;
    int    last_change = 0;
    bit    checking = 1'b0;
    logic  exp_sdo = 1'b0;
    string cur_req = "R1";
    int    n_checks = 0;
    int    n_fail = 0;

    logic [15:0] m_ch [CH];
    logic [15:0] m_gl;

    cfg_serial_port #(.CHANNELS(CH), .SYNC_STAGES(2)) i_cfg_serial_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_i   (cs),
        .sclk_i (sclk),
        .sdi_i  (sdi),
        .sdo_o  (sdo)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Comparator and watchdog.
    always @(negedge clk) begin
        if (checking && (cyc - last_change) >= SETTLE) begin
            n_checks++;
            if (sdo !== exp_sdo) begin
                n_fail++;
                $display("FAIL %s: sdo=%b expected %b at cycle %0d", cur_req, sdo, exp_sdo, cyc);
            end
        end
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Reference CRC: xor into the top, shift, reduce by the 9-bit polynomial.
    function automatic logic [7:0] ref_crc(input bit q[$]);
        logic [8:0] r;
        r = 9'h08A;
        foreach (q[i]) begin
            r = r ^ {1'b0, q[i], 7'b0};
            r = r << 1;
            if (r[8]) r = r ^ 9'h107;
        end
        return r[7:0];
    endfunction

    task automatic push_bits(ref bit q[$], input logic [15:0] v, input int w);
        for (int i = w - 1; i >= 0; i--) q.push_back(v[i]);
    endtask

    task automatic build_frame(output bit q[$], input logic [3:0] code,
                               input logic [6:0] addr, input logic [15:0] data,
                               input bit corrupt);
        logic [7:0] c;
        q = {};
        push_bits(q, 16'(code), 4);
        if (code == 4'h1 || code == 4'h2) push_bits(q, 16'(addr), 7);
        if (code == 4'h1 || code == 4'h3) push_bits(q, data, 16);
        c = ref_crc(q);
        if (corrupt) c[0] = ~c[0];
        push_bits(q, 16'(c), 8);
    endtask

    // One serial bit: data while low, rise, fall, then the new expected sdo.
    task automatic sbit(input bit b, input logic e);
        sdi = b;
        tick(HP);
        sclk = 1'b1;
        tick(HP);
        sclk = 1'b0;
        exp_sdo = e;
        last_change = cyc;
    endtask

    task automatic cs_low();
        tick(HP);
        cs = 1'b0;
        exp_sdo = 1'b0;
        last_change = cyc;
        tick(2 * HP);
    endtask

    task automatic do_cmd(input logic [3:0] code, input logic [6:0] addr,
                          input logic [15:0] data, input bit corrupt,
                          input int extra, input string req);
        bit q[$];
        bit resp[$];
        bit ok;
        bit rd;
        bit wr;
        logic [15:0] val;
        cur_req = req;
        build_frame(q, code, addr, data, corrupt);
        rd = (code == 4'h2 || code == 4'h4);
        wr = (code == 4'h1 || code == 4'h3);
        ok = !corrupt && (rd || wr) && !((code == 4'h1 || code == 4'h2) && addr >= CH);
        resp.push_back(ok);
        if (ok && rd) begin
            bit dq[$];
            val = (code == 4'h2) ? m_ch[addr] : m_gl;
            push_bits(dq, val, 16);
            push_bits(resp, val, 16);
            push_bits(resp, 16'(ref_crc(dq)), 8);
        end
        cs = 1'b1;
        last_change = cyc;
        tick(HP);
        for (int i = 0; i < q.size(); i++) begin
            sbit(q[i], (i == q.size() - 1) ? resp.pop_front() : 1'b0);
        end
        for (int e = 0; e < extra; e++) begin
            sbit(1'b1, (resp.size() > 0) ? resp.pop_front() : 1'b0);
        end
        cs_low();
        if (ok && wr && extra >= 3) begin
            if (code == 4'h1) m_ch[addr] = data;
            else              m_gl = data;
        end
    endtask

    task automatic do_abort(input logic [3:0] code, input logic [6:0] addr,
                            input logic [15:0] data, input int keep, input string req);
        bit q[$];
        cur_req = req;
        build_frame(q, code, addr, data, 1'b0);
        cs = 1'b1;
        last_change = cyc;
        tick(HP);
        for (int i = 0; i < keep; i++) sbit(q[i], 1'b0);
        cs_low();
    endtask

    initial begin
        for (int i = 0; i < CH; i++) m_ch[i] = '0;
        m_gl = '0;
        tick(5);
        rst_n = 1'b1;
        last_change = cyc;
        checking = 1'b1;
        cur_req = "R1";
        tick(20);
        // R1: reset values read back as zero
        do_cmd(4'h2, 7'd0, 16'h0, 1'b0, 26, "R1");
        do_cmd(4'h4, 7'd0, 16'h0, 1'b0, 26, "R1");
        // R2 R4 R7: channel write committed, then read back (R6)
        do_cmd(4'h1, 7'd3, 16'hA5C3, 1'b0, 3, "R7");
        do_cmd(4'h2, 7'd3, 16'h0, 1'b0, 26, "R6");
        // R11: global write leaves channels alone
        do_cmd(4'h3, 7'd0, 16'h1234, 1'b0, 3, "R11");
        do_cmd(4'h4, 7'd0, 16'h0, 1'b0, 26, "R11");
        do_cmd(4'h2, 7'd3, 16'h0, 1'b0, 26, "R11");
        // R3: corrupted CRC on write and read
        do_cmd(4'h1, 7'd2, 16'hFFFF, 1'b1, 4, "R3");
        do_cmd(4'h2, 7'd2, 16'h0, 1'b0, 26, "R3");
        do_cmd(4'h2, 7'd3, 16'h0, 1'b1, 26, "R3");
        // R5: last legal and first illegal address
        do_cmd(4'h1, 7'd5, 16'h8001, 1'b0, 3, "R5");
        do_cmd(4'h2, 7'd5, 16'h0, 1'b0, 26, "R5");
        do_cmd(4'h1, 7'd6, 16'h7777, 1'b0, 4, "R5");
        do_cmd(4'h2, 7'd6, 16'h0, 1'b0, 26, "R5");
        // R8: unknown codes
        do_cmd(4'h9, 7'd0, 16'h0, 1'b0, 26, "R8");
        do_cmd(4'h0, 7'd0, 16'h0, 1'b0, 26, "R8");
        // R7: chip select released one rise too early drops the write
        do_cmd(4'h1, 7'd1, 16'hBEEF, 1'b0, 2, "R7");
        do_cmd(4'h2, 7'd1, 16'h0, 1'b0, 26, "R7");
        // R9: partial frame then a full one
        do_abort(4'h1, 7'd1, 16'hDEAD, 20, "R9");
        do_cmd(4'h2, 7'd1, 16'h0, 1'b0, 26, "R9");
        do_cmd(4'h1, 7'd1, 16'h0F0F, 1'b0, 3, "R9");
        do_cmd(4'h2, 7'd1, 16'h0F0F, 1'b0, 26, "R9");
        // R10: extra clocks after the read CRC keep sdo low
        do_cmd(4'h2, 7'd5, 16'h0, 1'b0, 32, "R10");
        do_cmd(4'h4, 7'd0, 16'h0, 1'b0, 30, "R2");
        checking = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule